// File: doc/BRIEF.md
# Seconds Watchdog Register Slice

This block is the watchdog part of a real-time clock register file. A host reaches it over a simple register bus: an 8-bit address, 8-bit write data, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. A once-per-second tick enable drives the countdown. When the watchdog expires, the block drives an active-low reset pulse.

Software first writes the configuration register. One field selects the mode and another selects the countdown clock. Writing a nonzero value to the count register starts the watchdog, and each later write restarts it. Typical reload values run from 2 to 255 seconds, with 60 seconds as the usual default. Writing zero stops the watchdog. A read of a neighbouring status/control register also forces the count to zero, so a read of that address disarms the watchdog without any warning.

In watchdog mode, a countdown that expires holds the reset output low for one tick period. The output then returns high, and the count stays at zero.

Top module: `rtc_wdog`

## Requirements
- R1: After reset, the count and the configuration both read 0, `wd_rst_no` is high and `rdata_o` is 0.
- R2: A write to address 0x10 stores bits 7:6 (mode) and bits 1:0 (clock source). A read of 0x10 returns those bits in place and zero in bits 5:2.
- R3: A write to address 0x11 loads the count. A read of 0x11 returns the remaining count. Writing 0 stops the countdown.
- R4: The count drops by one on each cycle where `tick_i` is high, the source field is 2'b10 and the count is nonzero. While the source field holds any other value, the count stays frozen.
- R5: A count of 0 never decrements and never wraps.
- R6: A count write in the same cycle as an effective tick loads the written value, and that tick does not decrement the count.
- R7: Any read of address 0x01 forces the count to 0, which stops the watchdog. The read returns 0.
- R8: If an effective tick takes the count from 1 to 0 while the mode field is 2'b11, `wd_rst_no` goes low in the next cycle. In any other mode the output stays high.
- R9: Once `wd_rst_no` is low, it stays low until the next effective tick, which releases it. The count remains 0 unless software writes it.
- R10: A read of any address other than 0x01, 0x10 and 0x11 returns 0 and leaves the count unchanged. `rdata_o` is 0 in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| tick_i | input | 1 | Once-per-second tick enable |
| wd_rst_no | output | 1 | Active-low watchdog reset output |

## Verification
The bench builds the block with its default widths: an 8-bit bus and an 8-bit count. At that width the random phase can load the smallest counts (1 to 5). Expiry, the hold of the reset pulse and its release therefore happen many times within a few thousand cycles. It also lets the bench load the full range of 0 through 255. The random phase mixes ticks with reloads and disarming reads in the same cycle. It also drives clock-source values other than 2'b10, which reach the freeze path.

// File: rtl/rtc_wdog_pkg.sv
package rtc_wdog_pkg;
  typedef enum logic [1:0] {
    SRC_FAST0 = 2'b00,
    SRC_FAST1 = 2'b01,
    SRC_SEC   = 2'b10,
    SRC_MIN   = 2'b11
  } wd_src_e;

  typedef enum logic [1:0] {
    MODE_OFF0 = 2'b00,
    MODE_OFF1 = 2'b01,
    MODE_OFF2 = 2'b10,
    MODE_WDOG = 2'b11
  } wd_mode_e;

  typedef struct packed {
    wd_mode_e mode;
    wd_src_e  src;
  } wd_cfg_t;
endpackage

// File: rtl/rtc_wdog_dec.sv
module rtc_wdog_dec #(
  parameter int AW = 8,
  parameter logic [AW-1:0] CFG_ADDR  = 8'h10,
  parameter logic [AW-1:0] CNT_ADDR  = 8'h11,
  parameter logic [AW-1:0] STOP_ADDR = 8'h01
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic          cfg_we_o,
  output logic          cnt_we_o,
  output logic          cfg_re_o,
  output logic          cnt_re_o,
  output logic          stop_re_o
);
  always_comb begin
    cfg_we_o  = wr_i && (addr_i == CFG_ADDR);
    cnt_we_o  = wr_i && (addr_i == CNT_ADDR);
    cfg_re_o  = rd_i && (addr_i == CFG_ADDR);
    cnt_re_o  = rd_i && (addr_i == CNT_ADDR);
    stop_re_o = rd_i && (addr_i == STOP_ADDR);
  end
endmodule

// File: rtl/rtc_wdog_cfg.sv
module rtc_wdog_cfg
  import rtc_wdog_pkg::*;
#(
  parameter int DW       = 8,
  parameter int MODE_LSB = 6,
  parameter int SRC_LSB  = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output wd_cfg_t       cfg_o,
  output logic [DW-1:0] rb_o
);
  wd_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{mode: MODE_OFF0, src: SRC_FAST0};
    end else if (we_i) begin
      cfg_q.mode <= wd_mode_e'(wdata_i[MODE_LSB +: 2]);
      cfg_q.src  <= wd_src_e'(wdata_i[SRC_LSB +: 2]);
    end
  end

  always_comb begin
    rb_o = '0;
    rb_o[MODE_LSB +: 2] = cfg_q.mode;
    rb_o[SRC_LSB +: 2]  = cfg_q.src;
  end

  assign cfg_o = cfg_q;

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/rtc_wdog_cnt.sv
module rtc_wdog_cnt
  import rtc_wdog_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  wd_cfg_t       cfg_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          stop_i,
  output logic [CW-1:0] cnt_o,
  output logic          wd_rst_no
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          fire_q;
  logic          tick_en;
  logic          expire;

  assign tick_en = tick_i && (cfg_i.src == SRC_SEC);
  // bus actions override the tick
  assign expire  = tick_en && (cnt_q == ONE) && !load_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (stop_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_en && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_q <= 1'b0;
    end else if (expire && (cfg_i.mode == MODE_WDOG)) begin
      fire_q <= 1'b1;
    end else if (tick_en) begin
      fire_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign wd_rst_no = !fire_q;

  p_stop_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (cnt_o == '0));
  p_load_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !stop_i) |=> (cnt_o == $past(load_val_i)));
  p_decrement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_en && (cnt_o != '0) && !load_i && !stop_i) |=> (cnt_o == $past(cnt_o) - ONE));
  p_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_en && !load_i && !stop_i) |=> $stable(cnt_o));
  p_no_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_o == '0) && !load_i) |=> (cnt_o == '0));
  p_fire_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wd_rst_no) |-> ((cnt_o == '0) && ($past(cfg_i.mode) == MODE_WDOG)));
  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wd_rst_no && !tick_en) |=> !wd_rst_no);
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog
  import rtc_wdog_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 8,
  parameter logic [AW-1:0] CFG_ADDR  = 8'h10,
  parameter logic [AW-1:0] CNT_ADDR  = 8'h11,
  parameter logic [AW-1:0] STOP_ADDR = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_i,
  output logic          wd_rst_no
);
  logic          cfg_we, cnt_we, cfg_re, cnt_re, stop_re;
  wd_cfg_t       cfg;
  logic [DW-1:0] cfg_rb;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rdata_q;

  rtc_wdog_dec #(
    .AW(AW), .CFG_ADDR(CFG_ADDR), .CNT_ADDR(CNT_ADDR), .STOP_ADDR(STOP_ADDR)
  ) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .cfg_we_o(cfg_we), .cnt_we_o(cnt_we), .cfg_re_o(cfg_re),
    .cnt_re_o(cnt_re), .stop_re_o(stop_re)
  );

  rtc_wdog_cfg #(.DW(DW)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we), .wdata_i(wdata_i),
    .cfg_o(cfg), .rb_o(cfg_rb)
  );

  rtc_wdog_cnt #(.CW(CW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cfg_i(cfg),
    .load_i(cnt_we), .load_val_i(wdata_i[CW-1:0]), .stop_i(stop_re),
    .cnt_o(cnt), .wd_rst_no(wd_rst_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (cfg_re) rdata_q <= cfg_rb;
    else if (cnt_re) rdata_q <= DW'(cnt);
    else             rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
  p_count_rb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_re |=> (rdata_o == DW'($past(cnt))));
endmodule

// File: tb/rtc_wdog_test.sv
`timescale 1ns/1ps
module rtc_wdog_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] rdata_o;
  logic       wd_rst_no;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_cnt = '0, m_ctrl = '0, m_rd = '0;
  logic       m_fire = 1'b0;

  always #10 clk_i = ~clk_i;

  rtc_wdog uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .tick_i(tick_i),
    .wd_rst_no(wd_rst_no)
  );

  function automatic logic [7:0] f_cnt(logic [7:0] c, logic [7:0] ctl, logic w, logic r,
                                       logic [7:0] a, logic [7:0] d, logic t);
    if (r && a == 8'h01) return 8'h00;
    if (w && a == 8'h11) return d;
    if (t && ctl[1:0] == 2'b10 && c != 0) return c - 8'd1;
    return c;
  endfunction

  function automatic logic f_fire(logic f, logic [7:0] c, logic [7:0] ctl, logic w, logic r,
                                  logic [7:0] a, logic t);
    logic eff;
    eff = t && ctl[1:0] == 2'b10;
    if (eff && c == 8'd1 && !(r && a == 8'h01) && !(w && a == 8'h11) && ctl[7:6] == 2'b11)
      return 1'b1;
    if (eff) return 1'b0;
    return f;
  endfunction

  function automatic logic [7:0] f_rd(logic [7:0] c, logic [7:0] ctl, logic r, logic [7:0] a);
    if (!r) return 8'h00;
    if (a == 8'h10) return ctl;
    if (a == 8'h11) return c;
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic w, logic r, logic [7:0] a, logic [7:0] d, logic t);
    @(negedge clk_i);
    wr_i = w; rd_i = r; addr_i = a; wdata_i = d; tick_i = t;
    @(posedge clk_i);
    m_rd   = f_rd(m_cnt, m_ctrl, r, a);
    m_fire = f_fire(m_fire, m_cnt, m_ctrl, w, r, a, t);
    m_cnt  = f_cnt(m_cnt, m_ctrl, w, r, a, d, t);
    if (w && a == 8'h10) m_ctrl = d & 8'hC3;
    #1;
    check("R9 model", {7'd0, wd_rst_no}, {7'd0, !m_fire});
    check("R10 model", rdata_o, m_rd);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d); cyc(1'b1, 1'b0, a, d, 1'b0); endtask
  task automatic tk(); cyc(1'b0, 1'b0, 8'h00, 8'h00, 1'b1); endtask
  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string tag);
    cyc(1'b0, 1'b1, a, 8'h00, 1'b0);
    check(tag, rdata_o, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1 rst out", {7'd0, wd_rst_no}, 8'd1);
    check("R1 rdata", rdata_o, 8'h00);
    rd_chk(8'h11, 8'h00, "R1 count");
    rd_chk(8'h10, 8'h00, "R1 cfg");

    wr(8'h10, 8'hFF);
    rd_chk(8'h10, 8'hC3, "R2 cfg mask");
    wr(8'h10, 8'hC2);
    rd_chk(8'h10, 8'hC2, "R2 cfg");

    wr(8'h11, 8'd5);
    rd_chk(8'h11, 8'd5, "R3 load");
    wr(8'h11, 8'd255);
    rd_chk(8'h11, 8'd255, "R3 load max");
    wr(8'h11, 8'd5);
    tk(); tk(); tk();
    rd_chk(8'h11, 8'd2, "R4 decrement");
    wr(8'h10, 8'hC0);
    tk(); tk();
    rd_chk(8'h11, 8'd2, "R4 freeze src0");
    wr(8'h10, 8'hC3);
    tk();
    rd_chk(8'h11, 8'd2, "R4 freeze src3");
    wr(8'h10, 8'hC2);

    cyc(1'b1, 1'b0, 8'h11, 8'd9, 1'b1);
    rd_chk(8'h11, 8'd9, "R6 load over tick");

    wr(8'h11, 8'd0);
    tk();
    rd_chk(8'h11, 8'd0, "R3 stop");
    tk(); tk(); tk();
    rd_chk(8'h11, 8'd0, "R5 no wrap");
    check("R5 no reset", {7'd0, wd_rst_no}, 8'd1);

    wr(8'h11, 8'd4);
    rd_chk(8'h05, 8'h00, "R10 other addr");
    rd_chk(8'h11, 8'd4, "R10 no side effect");

    rd_chk(8'h01, 8'h00, "R7 stop read");
    rd_chk(8'h11, 8'd0, "R7 cleared");
    tk();
    check("R7 no reset", {7'd0, wd_rst_no}, 8'd1);

    wr(8'h11, 8'd2);
    tk(); tk();
    check("R8 expiry", {7'd0, wd_rst_no}, 8'd0);
    cyc(1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    cyc(1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R9 held", {7'd0, wd_rst_no}, 8'd0);
    rd_chk(8'h11, 8'd0, "R9 count zero");
    check("R9 held on read", {7'd0, wd_rst_no}, 8'd0);
    tk();
    check("R9 release", {7'd0, wd_rst_no}, 8'd1);

    wr(8'h10, 8'h02);
    wr(8'h11, 8'd1);
    tk();
    check("R8 other mode", {7'd0, wd_rst_no}, 8'd1);
    rd_chk(8'h11, 8'd0, "R8 other mode count");
    wr(8'h10, 8'hC2);

    for (int i = 0; i < 3000; i++) begin
      int unsigned sel;
      logic [7:0] a, d;
      logic w, r, t;
      sel = $urandom_range(0, 9);
      t = ($urandom_range(0, 2) == 0);
      w = 1'b0; r = 1'b0; a = 8'h00; d = 8'h00;
      case (sel)
        0, 1, 2: begin w = 1'b1; a = 8'h11; d = 8'($urandom_range(0, 5)); end
        3: begin w = 1'b1; a = 8'h10;
                 d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hC2; end
        4: begin r = 1'b1; a = 8'h01; end
        5, 6: begin r = 1'b1; a = 8'h11; end
        7: begin r = 1'b1; a = ($urandom_range(0, 1) == 0) ? 8'h10 : 8'h07; end
        default: ;
      endcase
      cyc(w, r, a, d, t);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule